// File: doc/BRIEF.md
# Scaled Shift-and-Add Execute Unit

This unit executes two fixed-point instructions that take two source registers and write one destination register. Each one doubles, quadruples, octuples or multiplies by sixteen the second operand and adds the first. The full-width form scales the whole 64-bit second operand. The word form first keeps only that operand's low 32 bits, zero-extended, so that an index held in a 32-bit register can be scaled into a 64-bit address without a separate masking step.

The unit takes a 32-bit instruction word together with both 64-bit operand values. It checks the primary and extended opcodes, extracts the destination register number and the 2-bit scale field, and captures everything in one register stage when `in_valid` is high. One clock later it presents the result, the destination number and, when the record bit is set, a 4-bit condition field. An instruction that matches neither opcode pair raises `illegal` in place of `out_valid`.

Top module: `scaled_add_unit`

## Requirements
- R1: Instruction fields use big-endian bit numbering, where bit 0 is `insn[31]`. The primary opcode is bits 0-5 (`insn[31:26]`), the destination number is bits 6-10 (`insn[25:21]`), the scale field is bits 21-22 (`insn[10:9]`), the extended opcode is bits 23-30 (`insn[8:1]`) and the record bit is bit 31 (`insn[0]`). `out_rt` carries the destination number.
- R2: For the full-width form (primary opcode PRIMARY_OP, extended opcode XO_FULL), `out_result = (rb_val << (sm+1)) + ra_val`.
- R3: The shift amount is the scale field plus one, so sm = 0, 1, 2, 3 multiplies the shifted operand by 2, 4, 8, 16. A zero field still doubles it.
- R4: For the word form (extended opcode XO_WORD), only `rb_val[31:0]` enters the shift, zero-extended to 64 bits. The upper half of `rb_val` has no effect on the result.
- R5: Bits shifted past bit 63 and the carry out of the 64-bit add are dropped, so the result wraps modulo 2^64.
- R6: An accepted instruction whose primary opcode differs from PRIMARY_OP, or whose extended opcode is neither XO_FULL nor XO_WORD, raises `illegal` for one cycle and keeps `out_valid` and `cr_we` low.
- R7: When the record bit is 1, `cr_we` rises with `out_valid` and `cr_field` = {LT, GT, EQ, SO}, bits 3 down to 0. LT, GT and EQ compare the result, read as signed, against zero, and exactly one of them is set. SO is `so_in` as captured with the instruction. When the record bit is 0, `cr_we` stays low.
- R8: Outputs for an instruction accepted at one rising edge are valid after the next edge for exactly one cycle. No output pulse appears unless `in_valid` was high at the preceding edge.
- R9: A synchronous active-high `rst` clears `out_valid`, `illegal` and `cr_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| insn | input | 32 | Instruction word |
| ra_val | input | 64 | Addend operand value |
| rb_val | input | 64 | Operand value to be scaled |
| so_in | input | 1 | Summary-overflow bit to copy into the condition field |
| out_valid | output | 1 | Result and destination are valid |
| out_result | output | 64 | Sum written to the destination register |
| out_rt | output | 5 | Destination register number |
| cr_we | output | 1 | Condition field update enable |
| cr_field | output | 4 | {LT, GT, EQ, SO} |
| illegal | output | 1 | Accepted instruction matched neither form |

## Verification
The cases hardest to reach from the ports are an exactly zero sum, which must set EQ, and a sum with the sign bit set after a wrap. Both depend on an addend chosen against the scaled value. The bench derives the addend as the two's complement of the scaled value (plus small offsets) for every scale and form, so EQ, LT and modulo-2^64 wrap all occur. The word-form sweep also puts nonzero patterns in the upper half of `rb_val`, and the expected values ignore that half.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int XLEN    = 64;
  localparam int HALF_W  = XLEN / 2;
  localparam int INSN_W  = 32;
  localparam int REG_W   = 5;
  localparam int SM_W    = 2;
  localparam int PO_W    = 6;
  localparam int XO_W    = 8;
  localparam int CR_W    = 4;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_FULL = 2'd1,
    OP_WORD = 2'd2
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [SM_W-1:0]   sm;
    logic              rc;
    logic [REG_W-1:0]  rt;
  } ctrl_t;

  // Scale the second operand by 2^(sm+1) and add the first, wrapping at XLEN.
  function automatic logic [XLEN-1:0] scale_add(
    input logic [XLEN-1:0] a,
    input logic [XLEN-1:0] b,
    input logic [SM_W-1:0] sm,
    input logic            word
  );
    logic [XLEN-1:0] src;
    logic [SM_W:0]   amt;
    src = word ? {{(XLEN-HALF_W){1'b0}}, b[HALF_W-1:0]} : b;
    amt = {1'b0, sm} + 1'b1;
    return (src << amt) + a;
  endfunction

  // Condition nibble {LT, GT, EQ, SO} from a signed view of the value.
  function automatic logic [CR_W-1:0] cond_of(
    input logic [XLEN-1:0] v,
    input logic            so
  );
    logic lt, gt, eq;
    eq = (v == '0);
    lt = v[XLEN-1];
    gt = !lt && !eq;
    return {lt, gt, eq, so};
  endfunction
endpackage

// File: rtl/sau_decode.sv
module sau_decode
  import sau_pkg::*;
#(
  parameter logic [PO_W-1:0] PRIMARY_OP = 6'd22,
  parameter logic [XO_W-1:0] XO_FULL    = 8'd110,
  parameter logic [XO_W-1:0] XO_WORD    = 8'd111
) (
  input  logic [INSN_W-1:0] insn,
  output ctrl_t             ctrl
);
  // Big-endian field k..m sits at vector bits (INSN_W-1-k) down to (INSN_W-1-m).
  localparam int PO_HI = INSN_W - 1;
  localparam int RT_HI = INSN_W - 1 - PO_W;
  localparam int SM_HI = INSN_W - 1 - 21;
  localparam int XO_HI = SM_HI - SM_W;

  logic [PO_W-1:0] po;
  logic [XO_W-1:0] xo;
  logic            po_hit;
  logic            unused_src_fields;

  assign po     = insn[PO_HI -: PO_W];
  assign xo     = insn[XO_HI -: XO_W];
  assign po_hit = (po == PRIMARY_OP);
  assign unused_src_fields = ^insn[RT_HI-REG_W -: 2*REG_W];

  always_comb begin
    ctrl.kind = OP_NONE;
    if (po_hit && xo == XO_FULL)      ctrl.kind = OP_FULL;
    else if (po_hit && xo == XO_WORD) ctrl.kind = OP_WORD;
    ctrl.sm = insn[SM_HI -: SM_W];
    ctrl.rc = insn[0];
    ctrl.rt = insn[RT_HI -: REG_W];
  end
endmodule

// File: rtl/sau_datapath.sv
module sau_datapath
  import sau_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            word_mode,
  input  logic [SM_W-1:0] sm,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] result
);
  localparam int MAX_SH = (1 << SM_W);

  assign result = scale_add(a, b, sm, word_mode);

  // Growth of the word form is bounded by HALF_W + MAX_SH bits above the addend.
  logic [XLEN-1:0] growth;
  assign growth = result - a;

  a_r4_word_growth_bounded: assert property (@(posedge clk) disable iff (rst)
    (active && word_mode) |-> (growth >> (HALF_W + MAX_SH)) == '0);
endmodule

// File: rtl/sau_flags.sv
module sau_flags
  import sau_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            so,
  input  logic [XLEN-1:0] value,
  output logic            we,
  output logic [CR_W-1:0] field
);
  assign we    = enable;
  assign field = cond_of(value, so);

  a_r7_one_relation: assert property (@(posedge clk) disable iff (rst)
    we |-> $countones(field[CR_W-1:1]) == 1);
  a_r7_eq_matches_zero: assert property (@(posedge clk) disable iff (rst)
    (we && field[1]) |-> value == '0);
endmodule

// File: rtl/scaled_add_unit.sv
module scaled_add_unit
  import sau_pkg::*;
#(
  parameter logic [PO_W-1:0] PRIMARY_OP = 6'd22,
  parameter logic [XO_W-1:0] XO_FULL    = 8'd110,
  parameter logic [XO_W-1:0] XO_WORD    = 8'd111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic              so_in,
  output logic              out_valid,
  output logic [XLEN-1:0]   out_result,
  output logic [REG_W-1:0]  out_rt,
  output logic              cr_we,
  output logic [CR_W-1:0]   cr_field,
  output logic              illegal
);
  ctrl_t           ctrl_d, ctrl_q;
  logic            v_q, so_q;
  logic [XLEN-1:0] ra_q, rb_q;
  logic            legal_q, word_q, rec_hit;

  sau_decode #(
    .PRIMARY_OP(PRIMARY_OP), .XO_FULL(XO_FULL), .XO_WORD(XO_WORD)
  ) u_decode (
    .insn (insn),
    .ctrl (ctrl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= in_valid;
    if (in_valid) begin
      ctrl_q <= ctrl_d;
      ra_q   <= ra_val;
      rb_q   <= rb_val;
      so_q   <= so_in;
    end
  end

  assign legal_q = (ctrl_q.kind != OP_NONE);
  assign word_q  = (ctrl_q.kind == OP_WORD);
  assign rec_hit = v_q && legal_q && ctrl_q.rc;

  sau_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .active    (out_valid),
    .word_mode (word_q),
    .sm        (ctrl_q.sm),
    .a         (ra_q),
    .b         (rb_q),
    .result    (out_result)
  );

  sau_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .enable (rec_hit),
    .so     (so_q),
    .value  (out_result),
    .we     (cr_we),
    .field  (cr_field)
  );

  assign out_valid = v_q && legal_q;
  assign illegal   = v_q && !legal_q;
  assign out_rt    = ctrl_q.rt;

  a_r8_valid_needs_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  a_r6_illegal_needs_input: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($past(in_valid) && !out_valid));
  a_r7_cr_with_result: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> out_valid);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> (!out_valid || $past(in_valid)));
endmodule

// File: tb/scaled_add_unit_bench.sv
module scaled_add_unit_bench;
  localparam logic [5:0] PO  = 6'd22;
  localparam logic [7:0] XOF = 8'd110;
  localparam logic [7:0] XOW = 8'd111;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] insn;
  logic [63:0] ra_val, rb_val;
  logic        so_in;
  logic        out_valid, cr_we, illegal;
  logic [63:0] out_result;
  logic [4:0]  out_rt;
  logic [3:0]  cr_field;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  scaled_add_unit u_scaled_add_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .ra_val(ra_val), .rb_val(rb_val), .so_in(so_in),
    .out_valid(out_valid), .out_result(out_result), .out_rt(out_rt),
    .cr_we(cr_we), .cr_field(cr_field), .illegal(illegal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent reference: multiply instead of shift, 65-bit sum then truncate.
  function automatic logic [63:0] ref_sum(input logic [63:0] a, input logic [63:0] b,
                                          input int sm, input bit word);
    logic [63:0]  src;
    logic [127:0] prod;
    logic [64:0]  s;
    src  = word ? (b % (64'd1 << 32)) : b;
    prod = {64'd0, src} * (128'd1 << (sm + 1));
    s    = {1'b0, prod[63:0]} + {1'b0, a};
    return s[63:0];
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] po, input logic [4:0] rt,
                                     input int sm, input logic [7:0] xo, input bit rc);
    logic [31:0] w;
    w = '0;
    w[31:26] = po;
    w[25:21] = rt;
    w[20:16] = 5'd3;
    w[15:11] = 5'd9;
    w[10:9]  = sm[1:0];
    w[8:1]   = xo;
    w[0]     = rc;
    return w;
  endfunction

  task automatic apply(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input bit so, input bit legal, input bit word, input int sm,
                       input bit rc);
    logic [63:0] e;
    logic [3:0]  ecr;
    @(negedge clk);
    insn = w; ra_val = a; rb_val = b; so_in = so; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    insn = '1; ra_val = '1; rb_val = '1; so_in = ~so;
    if (!legal) begin
      check("R6 illegal", {63'd0, illegal}, 64'd1);
      check("R6 valid low", {63'd0, out_valid}, 64'd0);
      check("R6 cr_we low", {63'd0, cr_we}, 64'd0);
    end else begin
      e = ref_sum(a, b, sm, word);
      ecr[3] = $signed(e) < 0;
      ecr[2] = $signed(e) > 0;
      ecr[1] = (e == 64'd0);
      ecr[0] = so;
      check(word ? "R4 R3 R5 word result" : "R2 R3 R5 full result", out_result, e);
      check("R8 valid", {63'd0, out_valid}, 64'd1);
      check("R1 rt", {59'd0, out_rt}, {59'd0, w[25:21]});
      check("R6 no illegal", {63'd0, illegal}, 64'd0);
      check("R7 cr_we", {63'd0, cr_we}, {63'd0, rc});
      if (rc) check("R7 cr_field", {60'd0, cr_field}, {60'd0, ecr});
    end
    @(posedge clk);
    @(negedge clk);
    check("R8 one cycle", {62'd0, out_valid, illegal}, 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] rbs [6];
    rbs[0] = 64'h0000_0000_0000_0001;
    rbs[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    rbs[2] = 64'hA5A5_0000_8000_0001;
    rbs[3] = 64'h8000_0000_0000_0000;
    rbs[4] = 64'h1234_5678_9ABC_DEF0;
    rbs[5] = 64'hDEAD_BEEF_7FFF_FFFF;
    rst = 1'b1; in_valid = 1'b0; insn = '0; ra_val = '0; rb_val = '0; so_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset cr_we", {63'd0, cr_we}, 64'd0);
    check("R9 reset illegal", {63'd0, illegal}, 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 idle no output", {62'd0, out_valid, illegal}, 64'd0);

    for (int wd = 0; wd < 2; wd++)
      for (int sm = 0; sm < 4; sm++)
        for (int k = 0; k < 6; k++)
          for (int off = 0; off < 3; off++) begin
            logic [63:0] scaled, a;
            scaled = ref_sum(64'd0, rbs[k], sm, wd[0]);
            // off 0: exact zero sum; off 1: -1; off 2: large positive addend (wrap)
            a = (off == 0) ? (64'd0 - scaled) :
                (off == 1) ? (64'd0 - scaled - 64'd1) : 64'h7FFF_FFFF_FFFF_FFF0 + k;
            apply(mk(PO, 5'(k + 8*sm + off), sm, wd[0] ? XOW : XOF, (off + k) % 2 == 0 || off == 0),
                  a, rbs[k], (k % 2) == 1, 1'b1, wd[0], sm, (off + k) % 2 == 0 || off == 0);
          end

    // R4: upper half of rb has no effect in word form
    apply(mk(PO, 5'd17, 2, XOW, 1'b1), 64'd5, 64'hFFFF_FFFF_0000_0003, 1'b0, 1'b1, 1'b1, 2, 1'b1);
    check("R4 upper ignored", out_result, 64'd0 + 64'd5 + 64'd24);
    // R3: sm=0 doubles
    apply(mk(PO, 5'd1, 0, XOF, 1'b0), 64'd0, 64'd21, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    // R6: wrong primary, wrong extended opcode
    apply(mk(PO ^ 6'd1, 5'd2, 1, XOF, 1'b1), 64'd1, 64'd1, 1'b1, 1'b0, 1'b0, 1, 1'b1);
    apply(mk(PO, 5'd2, 1, 8'd112, 1'b1), 64'd1, 64'd1, 1'b1, 1'b0, 1'b0, 1, 1'b1);
    apply(mk(6'd0, 5'd2, 3, XOW, 1'b0), 64'd1, 64'd1, 1'b0, 1'b0, 1'b1, 3, 1'b0);

    // R9: reset during a pending result suppresses it
    @(negedge clk);
    insn = mk(PO, 5'd4, 1, XOF, 1'b1); ra_val = 64'd1; rb_val = 64'd1; in_valid = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check("R9 reset drops pulse", {61'd0, out_valid, cr_we, illegal}, 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule